// File: doc/BRIEF.md
# Windowed Key-Serviced Watchdog Timer

This block is a watchdog that starts counting the moment reset is released. No software set-up is needed before it runs. An up-counter measures the cycles since the last valid service. Software restarts the counter by writing two fixed keys in a row to a service register.

A fault is raised when the counter reaches the programmed limit. A fault is also raised when the service register gets a wrong or out-of-order value, or when a correct service finishes while the optional early window is still closed. Depending on one configuration bit, a fault either pulses a reset request for one cycle or raises an interrupt that stays asserted. In interrupt mode, a second fault that arrives before the interrupt is cleared escalates to a reset request.

The limit, window and action registers are guarded by a lock. A parameter picks one of two lock schemes:
- **Key lock:** the registers are sealed after reset, and a key opens them for exactly one write.
- **Write-once:** the registers are open after reset and seal themselves after the first write.

Writes that the lock refuses leave every register unchanged and set a sticky access-error bit.

There are three state machines:
- **Action machine:** `W_RUN`, `W_WARNED`, `W_FIRE`.
  - `W_RUN` goes to `W_FIRE` on a fault in reset mode (escalate).
  - `W_RUN` goes to `W_WARNED` on a fault in interrupt mode (warn).
  - `W_WARNED` goes to `W_RUN` when software clears the flag (acknowledge).
  - `W_WARNED` goes to `W_FIRE` on another fault (escalate).
  - `W_FIRE` always returns to `W_RUN` after one cycle (release).
- **Service machine:** `SVC_IDLE`, `SVC_HALF`.
  - The first key moves `SVC_IDLE` to `SVC_HALF` (arm).
  - Any write in `SVC_HALF` returns to `SVC_IDLE` (complete or reject).
  - A wrong write in `SVC_IDLE` stays there (reject).
- **Lock machine:** `CFG_SEALED`, `CFG_OPEN`.
  - The unlock key moves `CFG_SEALED` to `CFG_OPEN` (open).
  - Any configuration write moves `CFG_OPEN` to `CFG_SEALED` (consume).

Top module: `wdt_keyed`

## Requirements
- R1: After reset, TIMEOUT (address 1) reads 0xFFFF, WINDOW (address 2) reads 0, and CTRL bit 0 reads 0 (reset action). COUNT (address 6) advances by one every clock with no software action.
- R2: When COUNT reaches TIMEOUT without a valid service, a fault occurs and COUNT restarts at 0. In reset mode, `rst_req` is high for exactly one cycle, T+1 cycles after the counter last restarted, where T is the TIMEOUT value.
- R3: Writing 0xA602 and then 0xB480 to SERVICE (address 3) in consecutive writes to that register restarts COUNT at 0. No fault is raised when the window allows it.
- R4: Any other value written to SERVICE is a fault. This includes 0xB480 without a preceding 0xA602, and anything other than 0xB480 after 0xA602. The fault is handled exactly like a timeout and takes effect on the clock edge of the offending write.
- R5: With WINDOW non-zero, a service whose second key is written while COUNT < WINDOW is a fault. A service completed when COUNT >= WINDOW is accepted. WINDOW = 0 disables the check.
- R6: With CTRL bit 0 = 1 (interrupt action), a fault raises `irq`. `irq` stays high and reads as STATUS (address 5) bit 0 until a write of 1 to STATUS bit 0 clears it.
- R7: A fault while `irq` is high produces a one-cycle `rst_req` pulse, and `irq` is low during that pulse.
- R8: With the key lock (WRITE_ONCE = 0), CTRL, TIMEOUT and WINDOW are sealed after reset. Writing 0xC3D2 to UNLOCK (address 4) opens them for exactly one configuration write. STATUS bit 2 reads 1 while they are open.
- R9: With WRITE_ONCE = 1, the configuration is open after reset. The first configuration write seals it until reset, and unlock writes never reopen it.
- R10: A refused configuration write leaves the register unchanged and sets STATUS bit 1. A wrong unlock key, or any unlock write in write-once mode, also sets STATUS bit 1. Writing 1 to STATUS bit 1 clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Level interrupt request, held until cleared |

## Verification
The hardest state to reach from the ports is the escalation path. The bench has to unlock twice, switch the block to interrupt action with a short limit, and then let a second timeout expire while the first interrupt is still pending. Directed sequences build that state with exact cycle counts and check where the reset pulse lands relative to the interrupt. A seeded random loop draws a limit and an idle wait for each round. The wait is kept either safely below the limit or just past it, so the bench model can say exactly whether one reset pulse must appear. The write-once lock is checked on a second instance built with the other lock parameter.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [2:0] {
        RA_CTRL    = 3'd0,
        RA_TIMEOUT = 3'd1,
        RA_WINDOW  = 3'd2,
        RA_SERVICE = 3'd3,
        RA_UNLOCK  = 3'd4,
        RA_STATUS  = 3'd5,
        RA_COUNT   = 3'd6,
        RA_SPARE   = 3'd7
    } reg_addr_e;

    localparam logic [15:0] SVC_KEY_FIRST  = 16'hA602;
    localparam logic [15:0] SVC_KEY_SECOND = 16'hB480;
    localparam logic [15:0] CFG_UNLOCK_KEY = 16'hC3D2;

    typedef enum logic [1:0] {W_RUN, W_WARNED, W_FIRE} wd_state_e;
    typedef enum logic {SVC_IDLE, SVC_HALF} svc_state_e;
    typedef enum logic {CFG_SEALED, CFG_OPEN} cfg_state_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int DATA_W     = 32,
    parameter bit WRITE_ONCE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_addr_e         addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  timeout_q,
    output logic [CNT_W-1:0]  window_q,
    output logic              irq_mode,
    output logic              cfg_open,
    output logic              acc_err,
    output logic              clr_flag
);
    localparam cfg_state_e CFG_RESET = WRITE_ONCE ? CFG_OPEN : CFG_SEALED;
    localparam logic [DATA_W-1:0] UNLOCK_WORD = DATA_W'(CFG_UNLOCK_KEY);

    cfg_state_e state_q, state_d;
    logic cfg_write, unlock_write, good_unlock, refused;

    always_comb begin
        cfg_write    = wr_en && (addr == RA_CTRL || addr == RA_TIMEOUT || addr == RA_WINDOW);
        unlock_write = wr_en && (addr == RA_UNLOCK);
        good_unlock  = unlock_write && !WRITE_ONCE && (wdata == UNLOCK_WORD);
        refused      = (cfg_write && state_q == CFG_SEALED) ||
                       (unlock_write && !good_unlock);
        clr_flag     = wr_en && (addr == RA_STATUS) && wdata[0];
    end

    // Lock state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_RESET;
        else        state_q <= state_d;
    end

    // Lock transitions: open, consume
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_SEALED: if (good_unlock) state_d = CFG_OPEN;
            CFG_OPEN:   if (cfg_write)   state_d = CFG_SEALED;
            default:    state_d = CFG_SEALED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timeout_q <= '1;
            window_q  <= '0;
            irq_mode  <= 1'b0;
            acc_err   <= 1'b0;
        end else begin
            if (cfg_write && state_q == CFG_OPEN) begin
                unique case (addr)
                    RA_CTRL:    irq_mode  <= wdata[0];
                    RA_TIMEOUT: timeout_q <= wdata[CNT_W-1:0];
                    RA_WINDOW:  window_q  <= wdata[CNT_W-1:0];
                    default:    ;
                endcase
            end
            if (refused)
                acc_err <= 1'b1;
            else if (wr_en && addr == RA_STATUS && wdata[1])
                acc_err <= 1'b0;
        end
    end

    always_comb cfg_open = (state_q == CFG_OPEN);
endmodule

// File: rtl/wdt_service.sv
module wdt_service
    import wdt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              svc_write,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  elapsed,
    input  logic [CNT_W-1:0]  window_q,
    output logic              svc_ok,
    output logic              svc_bad
);
    localparam logic [DATA_W-1:0] FIRST_WORD  = DATA_W'(SVC_KEY_FIRST);
    localparam logic [DATA_W-1:0] SECOND_WORD = DATA_W'(SVC_KEY_SECOND);

    svc_state_e state_q, state_d;
    logic window_open;

    always_comb window_open = (elapsed >= window_q);

    // Service state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SVC_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: arm, complete, reject
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SVC_IDLE: if (svc_write && wdata == FIRST_WORD) state_d = SVC_HALF;
            SVC_HALF: if (svc_write)                        state_d = SVC_IDLE;
            default:  state_d = SVC_IDLE;
        endcase
    end

    // Outputs per accepted or rejected write
    always_comb begin
        svc_ok  = 1'b0;
        svc_bad = 1'b0;
        unique case (state_q)
            SVC_IDLE: svc_bad = svc_write && (wdata != FIRST_WORD);
            SVC_HALF: begin
                svc_ok  = svc_write && (wdata == SECOND_WORD) && window_open;
                svc_bad = svc_write && !((wdata == SECOND_WORD) && window_open);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] timeout_q,
    input  logic             irq_mode,
    input  logic             svc_ok,
    input  logic             svc_bad,
    input  logic             clr_flag,
    output logic [CNT_W-1:0] elapsed,
    output logic             fault,
    output logic             irq,
    output logic             rst_req
);
    wd_state_e state_q, state_d;
    logic expired;

    always_comb begin
        expired = (elapsed >= timeout_q);
        fault   = expired || svc_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                elapsed <= '0;
        else if (fault || svc_ok)  elapsed <= '0;
        else                       elapsed <= elapsed + 1'b1;
    end

    // Action state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= W_RUN;
        else        state_q <= state_d;
    end

    // Transitions: warn, escalate, acknowledge, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_RUN:    if (fault) state_d = irq_mode ? W_WARNED : W_FIRE;
            W_WARNED: begin
                if (fault)         state_d = W_FIRE;
                else if (clr_flag) state_d = W_RUN;
            end
            W_FIRE:   state_d = W_RUN;
            default:  state_d = W_RUN;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        irq     = (state_q == W_WARNED);
        rst_req = (state_q == W_FIRE);
    end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int DATA_W     = 32,
    parameter bit WRITE_ONCE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req,
    output logic              irq
);
    localparam int PAD_W = DATA_W - CNT_W;

    reg_addr_e        addr;
    logic [CNT_W-1:0] timeout_q, window_q, elapsed;
    logic             irq_mode, cfg_open, acc_err, clr_flag;
    logic             svc_ok, svc_bad, fault;

    always_comb addr = reg_addr_e'(bus_addr);

    wdt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .WRITE_ONCE(WRITE_ONCE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(addr), .wdata(bus_wdata),
        .timeout_q(timeout_q), .window_q(window_q), .irq_mode(irq_mode),
        .cfg_open(cfg_open), .acc_err(acc_err), .clr_flag(clr_flag)
    );

    wdt_service #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_service (
        .clk(clk), .rst_n(rst_n), .svc_write(bus_wr && addr == RA_SERVICE),
        .wdata(bus_wdata), .elapsed(elapsed), .window_q(window_q),
        .svc_ok(svc_ok), .svc_bad(svc_bad)
    );

    wdt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .timeout_q(timeout_q), .irq_mode(irq_mode),
        .svc_ok(svc_ok), .svc_bad(svc_bad), .clr_flag(clr_flag),
        .elapsed(elapsed), .fault(fault), .irq(irq), .rst_req(rst_req)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (addr)
            RA_CTRL:    bus_rdata = {{(DATA_W-1){1'b0}}, irq_mode};
            RA_TIMEOUT: bus_rdata = {{PAD_W{1'b0}}, timeout_q};
            RA_WINDOW:  bus_rdata = {{PAD_W{1'b0}}, window_q};
            RA_STATUS:  bus_rdata = {{(DATA_W-3){1'b0}}, cfg_open, acc_err, irq};
            RA_COUNT:   bus_rdata = {{PAD_W{1'b0}}, elapsed};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req,
    input logic             irq,
    input logic             fault,
    input logic             clr_flag,
    input logic             svc_ok,
    input logic             cfg_open,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic [CNT_W-1:0] elapsed,
    input logic [CNT_W-1:0] timeout_q,
    input logic [CNT_W-1:0] window_q
);
    assert_count_advances_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fault && !svc_ok |=> elapsed == CNT_W'($past(elapsed) + 1'b1));

    assert_rst_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_refresh_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> elapsed == '0);

    assert_window_respected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |-> elapsed >= window_q);

    assert_irq_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !fault && !clr_flag |=> irq);

    assert_escalate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq && fault |=> rst_req && !irq);

    assert_sealed_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 3'd1 && !cfg_open |=> $stable(timeout_q));
endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq(irq), .fault(fault),
    .clr_flag(clr_flag), .svc_ok(svc_ok), .cfg_open(cfg_open), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .elapsed(elapsed), .timeout_q(timeout_q), .window_q(window_q)
);

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr0 = 1'b0, wr1 = 1'b0;
    logic [31:0] rdata0, rdata1;
    logic        rst0, irq0, rst1, irq1;
    int          checks = 0, fails = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    wdt_keyed u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_wr(wr0),
        .bus_rdata(rdata0), .rst_req(rst0), .irq(irq0)
    );

    wdt_keyed #(.WRITE_ONCE(1'b1)) u_dut_once (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_wr(wr1),
        .bus_rdata(rdata1), .rst_req(rst1), .irq(irq1)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr0 = !sel; wr1 = sel;
        @(negedge clk);
        wr0 = 1'b0; wr1 = 1'b0;
    endtask

    task automatic rd(input bit sel, input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = sel ? rdata1 : rdata0;
    endtask

    task automatic service();
        wr(0, 3'd3, 32'hA602);
        wr(0, 3'd3, 32'hB480);
    endtask

    task automatic set_cfg(input logic [2:0] a, input logic [31:0] d);
        wr(0, 3'd4, 32'hC3D2);
        wr(0, a, d);
    endtask

    // Cycles until rst_req is seen, 0 if never within max
    task automatic until_rst(input int max, output int k);
        k = 0;
        for (int i = 1; i <= max; i++) begin
            @(negedge clk);
            if (rst0) begin k = i; break; end
        end
    endtask

    task automatic until_irq(input int max, output int k);
        k = 0;
        for (int i = 1; i <= max; i++) begin
            @(negedge clk);
            if (irq0) begin k = i; break; end
        end
    endtask

    function automatic int fire_expect(input int t, input int d);
        return (d >= t + 1) ? 1 : 0;
    endfunction

    initial begin
        logic [31:0] v, v2;
        int k, t, d, pulses;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and free running
        rd(0, 3'd1, v); check("R1 timeout default", v, 32'hFFFF);
        rd(0, 3'd2, v); check("R1 window default", v, 0);
        rd(0, 3'd0, v); check("R1 ctrl default", v, 0);
        check("R1 no outputs", {30'd0, rst0, irq0}, 0);
        rd(0, 3'd6, v); @(negedge clk); rd(0, 3'd6, v2);
        check("R1 count advances", v2 - v, 1);

        // R8 / R10 sealed after reset
        rd(0, 3'd5, v); check("R8 sealed after reset", v[2], 0);
        wr(0, 3'd1, 32'd20);
        rd(0, 3'd1, v); check("R10 refused write", v, 32'hFFFF);
        rd(0, 3'd5, v); check("R10 error set", v[1], 1);
        wr(0, 3'd5, 32'h2);
        rd(0, 3'd5, v); check("R10 error cleared", v[1], 0);
        wr(0, 3'd4, 32'h1234);
        rd(0, 3'd5, v); check("R10 wrong key error", {v[2], v[1]}, 2'b01);
        wr(0, 3'd5, 32'h2);

        // R8 one write per unlock
        wr(0, 3'd4, 32'hC3D2);
        rd(0, 3'd5, v); check("R8 open flag", v[2], 1);
        wr(0, 3'd1, 32'd20);
        rd(0, 3'd1, v); check("R8 accepted", v, 20);
        rd(0, 3'd5, v); check("R8 resealed", v[2], 0);
        wr(0, 3'd1, 32'd30);
        rd(0, 3'd1, v); check("R8 second write refused", v, 20);
        wr(0, 3'd5, 32'h2);

        // R3 service restarts, R2 timeout pulse
        service();
        rd(0, 3'd6, v); check("R3 count restarted", v, 0);
        until_rst(40, k); check("R2 timeout cycle", k, 21);
        @(negedge clk); check("R2 pulse one cycle", rst0, 0);

        // R4 bad keys
        wr(0, 3'd3, 32'h1234);
        check("R4 wrong value", rst0, 1);
        wr(0, 3'd3, 32'hB480);
        check("R4 second key alone", rst0, 1);
        wr(0, 3'd3, 32'hA602);
        wr(0, 3'd3, 32'hA602);
        check("R4 first key twice", rst0, 1);

        // R5 window
        set_cfg(3'd2, 32'd10);
        service();
        check("R5 early service", rst0, 1);
        repeat (12) @(negedge clk);
        service();
        check("R5 in-window service", rst0, 0);
        rd(0, 3'd6, v); check("R5 count restarted", v, 0);
        set_cfg(3'd2, 32'd0);

        // R2 / R3 randomized limits and waits
        for (int it = 0; it < 30; it++) begin
            t = 10 + int'($urandom % 22);
            d = ($urandom % 2 == 1) ? int'($urandom % (t - 6)) : t + 1 + int'($urandom % 3);
            set_cfg(3'd1, t);
            service();
            pulses = 0;
            for (int i = 0; i < d; i++) begin
                @(negedge clk);
                if (rst0) pulses++;
            end
            check($sformatf("R2 random t=%0d d=%0d", t, d), pulses, fire_expect(t, d));
        end

        // R6 interrupt action
        set_cfg(3'd0, 32'd1);
        set_cfg(3'd1, 32'd15);
        service();
        until_irq(40, k); check("R6 irq on timeout", k, 16);
        check("R6 no reset", rst0, 0);
        rd(0, 3'd5, v); check("R6 status flag", v[0], 1);
        repeat (3) @(negedge clk);
        check("R6 irq held", irq0, 1);
        wr(0, 3'd5, 32'h1);
        check("R6 cleared", irq0, 0);

        // R7 escalation
        service();
        until_irq(40, k); check("R7 first fault warns", k, 16);
        until_rst(40, k); check("R7 escalation cycle", k, 16);
        check("R7 irq dropped", irq0, 0);

        // R9 write-once instance
        rd(1, 3'd5, v); check("R9 open after reset", v[2], 1);
        wr(1, 3'd1, 32'd40);
        rd(1, 3'd1, v); check("R9 first write", v, 40);
        wr(1, 3'd1, 32'd50);
        rd(1, 3'd1, v); check("R9 second write refused", v, 40);
        rd(1, 3'd5, v); check("R10 write-once error", v[1], 1);
        wr(1, 3'd5, 32'h2);
        wr(1, 3'd4, 32'hC3D2);
        rd(1, 3'd5, v); check("R9 unlock ignored", {v[2], v[1]}, 2'b01);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule